// File: doc/BRIEF.md
# LPI Table Base Register Pair with Attribute Sanitising

This block keeps two 64-bit table base registers, one locating the LPI property table and one locating the LPI pending table, and a single LPI-enable flag. Software reaches all three through a small memory-mapped port. Each access is either 32 bits wide, aimed at the low or high word, or 64 bits wide.

Each accepted write folds the addressed word into the current register value. The result is then cleaned before it is stored:
- Shareability and cacheability encodings that the memory system must not see are replaced by legal ones.
- Reserved bits are forced to zero.

The stored values and the enable flag drive the outputs directly, so downstream logic only ever sees legal encodings. The base registers are frozen while LPIs are enabled. Setting the enable flag emits a one-cycle start pulse for the logic that begins using the tables.

Register map (byte offsets):
- 0x00: control, bit 0 = LPI enable.
- 0x08: property base.
- 0x10: pending base.

Address bit 2 picks the high word for 32-bit accesses.

Top module: `lpi_base_regs`

## Requirements
- R1: A 32-bit write with address bit 2 clear replaces bits 31:0 and a 32-bit write with bit 2 set replaces bits 63:32, keeping the other word; a 64-bit write replaces all 64 bits.
- R2: A shareability field (bits 11:10; 0 none, 1 inner, 2 outer) written as 2 is stored as 1; other values are stored as written.
- R3: An inner cacheability field (bits 9:7) written as 0 (device) or 1 (non-cacheable) is stored as 7 (read-allocate write-back); other values are stored as written.
- R4: An outer cacheability field (bits 58:56) is stored as written when it is 0 (same as inner) or 1 (non-cacheable) and as 1 otherwise.
- R5: The property base always stores bits 63:59, 55:52 and 6:5 as zero.
- R6: The pending base always stores bit 63 and bits 61:59, 55:52, 15:12 and 6:0 as zero; bit 62 is kept.
- R7: Both bases always store bits 51:48 as zero.
- R8: Writes to either base register leave it unchanged while the LPI-enable flag is 1.
- R9: Bit 0 of a write to offset 0x00 sets or clears the enable flag only when parameter HAS_XLAT is 1; with HAS_XLAT 0 the flag stays 0. A read of offset 0x00 returns the flag in bit 0.
- R10: lpi_start is high for exactly one cycle, the first cycle in which lpi_en is 1 after being 0; rewriting 1 to an enabled flag gives no pulse.
- R11: A read returns the selected register shifted right by 32 when address bit 2 is set, masked to the low 32 bits for a 32-bit read.
- R12: After reset both bases and the enable flag are zero and lpi_start is low.
- R13: Accesses whose address bits 1:0 are not zero are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Write byte address |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_data | input | 64 | Write data (bits 31:0 for 32-bit writes) |
| rd_addr | input | 5 | Read byte address |
| rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| rd_data | output | 64 | Read data, combinational from rd_addr |
| prop_base | output | 64 | Stored property table base |
| pend_base | output | 64 | Stored pending table base |
| lpi_en | output | 1 | LPI enable flag |
| lpi_start | output | 1 | One-cycle pulse on enable rising |

## Verification
If a sanitising path is wrong, an illegal attribute code or a reserved bit shows on prop_base or pend_base in the cycle after the offending write, and it shows identically through rd_data. A merge fault shows as a corrupted neighbouring word on the next read. If the lock is wrong, a base value changes while lpi_en is high, one cycle after a base write. If the edge detector is wrong, lpi_start is missing, lasts too long or repeats on a redundant enable write, which is visible in the very cycle lpi_en rises.

// File: rtl/lpi_base_pkg.sv
package lpi_base_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned ADDR_W = 5;

  // attribute field positions, shared by both base registers
  localparam int unsigned SH_LO = 10;
  localparam int unsigned SH_W  = 2;
  localparam int unsigned IC_LO = 7;
  localparam int unsigned OC_LO = 56;
  localparam int unsigned CA_W  = 3;

  localparam logic [SH_W-1:0] SH_INNER = 2'd1;
  localparam logic [SH_W-1:0] SH_OUTER = 2'd2;
  localparam logic [CA_W-1:0] CA_DEV   = 3'd0;
  localparam logic [CA_W-1:0] CA_NC    = 3'd1;
  localparam logic [CA_W-1:0] CA_RAWB  = 3'd7;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_PROP = 2'd1,
    SLOT_PEND = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  function automatic logic [REG_W-1:0] bit_span(input int unsigned hi, input int unsigned lo);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned b = lo; b <= hi; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] ADDR_HOLE_MASK = bit_span(51, 48);
  localparam logic [REG_W-1:0] PROP_RSVD_MASK =
    bit_span(63, 59) | bit_span(55, 52) | bit_span(6, 5);
  localparam logic [REG_W-1:0] PEND_RSVD_MASK =
    bit_span(63, 63) | bit_span(61, 59) | bit_span(55, 52) |
    bit_span(15, 12) | bit_span(6, 0);
endpackage

// File: rtl/lpi_rst_sync.sv
module lpi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/lpi_half_merge.sv
module lpi_half_merge
  import lpi_base_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic [REG_W-1:0] wdata,
  input  logic             wide,
  input  logic             hi,
  output logic [REG_W-1:0] merged
);
  always_comb begin
    if (wide)    merged = wdata;
    else if (hi) merged = {wdata[HALF_W-1:0], cur[HALF_W-1:0]};
    else         merged = {cur[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
  end
endmodule

// File: rtl/lpi_attr_sanitiser.sv
module lpi_attr_sanitiser
  import lpi_base_pkg::*;
#(
  parameter logic [REG_W-1:0] RSVD_MASK = '0
) (
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] clean
);
  localparam logic [REG_W-1:0] CLEAR_MASK = RSVD_MASK | ADDR_HOLE_MASK;

  logic [SH_W-1:0] sh_in, sh_out;
  logic [CA_W-1:0] ic_in, ic_out, oc_in, oc_out;
  logic [REG_W-1:0] fixed;

  always_comb begin
    sh_in = raw[SH_LO +: SH_W];
    ic_in = raw[IC_LO +: CA_W];
    oc_in = raw[OC_LO +: CA_W];

    sh_out = (sh_in == SH_OUTER) ? SH_INNER : sh_in;
    ic_out = ((ic_in == CA_DEV) || (ic_in == CA_NC)) ? CA_RAWB : ic_in;
    oc_out = ((oc_in == CA_DEV) || (oc_in == CA_NC)) ? oc_in : CA_NC;

    fixed = raw;
    fixed[SH_LO +: SH_W] = sh_out;
    fixed[IC_LO +: CA_W] = ic_out;
    fixed[OC_LO +: CA_W] = oc_out;
    clean = fixed & ~CLEAR_MASK;
  end
endmodule

// File: rtl/lpi_base_slot.sv
module lpi_base_slot
  import lpi_base_pkg::*;
#(
  parameter logic [REG_W-1:0] RSVD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             wr_wide,
  input  logic             wr_hi,
  input  logic [REG_W-1:0] wr_data,
  input  logic             locked,
  output logic [REG_W-1:0] value
);
  logic [REG_W-1:0] value_q, merged, cleaned, value_d;
  logic             load_en;

  lpi_half_merge u_merge (
    .cur    (value_q),
    .wdata  (wr_data),
    .wide   (wr_wide),
    .hi     (wr_hi),
    .merged (merged)
  );

  lpi_attr_sanitiser #(.RSVD_MASK(RSVD_MASK)) u_sanit (
    .raw   (merged),
    .clean (cleaned)
  );

  always_comb begin
    load_en = wr_hit && !locked;
    value_d = cleaned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= '0;
    else if (load_en) value_q <= value_d;
  end

  assign value = value_q;

  a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && locked) |=> $stable(value_q));
  a_r2_no_outer_share: assert property (@(posedge clk) disable iff (!rst_n)
    value_q[SH_LO +: SH_W] != SH_OUTER);
  a_r3_inner_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !locked) |=> (value_q[IC_LO +: CA_W] != CA_DEV && value_q[IC_LO +: CA_W] != CA_NC));
  a_r4_outer_legal: assert property (@(posedge clk) disable iff (!rst_n)
    value_q[OC_LO +: CA_W] <= CA_NC);
  a_r5_r6_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q & RSVD_MASK) == '0);
  a_r7_hole_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q & ADDR_HOLE_MASK) == '0);
endmodule

// File: rtl/lpi_base_regs.sv
module lpi_base_regs
  import lpi_base_pkg::*;
#(
  parameter bit HAS_XLAT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_wide,
  output logic [REG_W-1:0]  rd_data,
  output logic [REG_W-1:0]  prop_base,
  output logic [REG_W-1:0]  pend_base,
  output logic              lpi_en,
  output logic              lpi_start
);
  localparam int unsigned N_SLOTS = 2;

  logic        rst_n_s;
  slot_e       wr_slot, rd_slot;
  logic        wr_aligned, rd_aligned, ctrl_wr;
  logic [N_SLOTS-1:0] slot_hit;
  logic [REG_W-1:0]   slot_val [N_SLOTS];
  logic        en_q, en_d, start_q, start_d;
  logic [REG_W-1:0] rd_sel, rd_shift;

  lpi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // write decode
  always_comb begin
    wr_slot    = slot_e'(wr_addr[4:3]);
    wr_aligned = (wr_addr[1:0] == 2'b00);
    ctrl_wr    = wr_en && wr_aligned && (wr_slot == SLOT_CTRL) && (wr_wide || !wr_addr[2]);
    slot_hit[0] = wr_en && wr_aligned && (wr_slot == SLOT_PROP);
    slot_hit[1] = wr_en && wr_aligned && (wr_slot == SLOT_PEND);
  end

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      localparam logic [REG_W-1:0] SLOT_MASK = (g == 0) ? PROP_RSVD_MASK : PEND_RSVD_MASK;
      lpi_base_slot #(.RSVD_MASK(SLOT_MASK)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .wr_hit  (slot_hit[g]),
        .wr_wide (wr_wide),
        .wr_hi   (wr_addr[2]),
        .wr_data (wr_data),
        .locked  (en_q),
        .value   (slot_val[g])
      );
    end
  endgenerate

  // enable flag and start pulse: next state
  always_comb begin
    en_d = en_q;
    if (ctrl_wr && HAS_XLAT) en_d = wr_data[0];
    start_d = en_d && !en_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      start_q <= start_d;
    end
  end

  // read path
  always_comb begin
    rd_slot    = slot_e'(rd_addr[4:3]);
    rd_aligned = (rd_addr[1:0] == 2'b00);
    unique case (rd_slot)
      SLOT_CTRL: rd_sel = {{(REG_W-1){1'b0}}, en_q};
      SLOT_PROP: rd_sel = slot_val[0];
      SLOT_PEND: rd_sel = slot_val[1];
      default:   rd_sel = '0;
    endcase
    rd_shift = rd_addr[2] ? {{HALF_W{1'b0}}, rd_sel[REG_W-1:HALF_W]} : rd_sel;
    if (!rd_aligned)  rd_data = '0;
    else if (rd_wide) rd_data = rd_shift;
    else              rd_data = {{HALF_W{1'b0}}, rd_shift[HALF_W-1:0]};
  end

  assign prop_base = slot_val[0];
  assign pend_base = slot_val[1];
  assign lpi_en    = en_q;
  assign lpi_start = start_q;

  a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_q |=> !start_q);
  a_r10_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_q |-> (en_q && !$past(en_q)));
  a_r9_enable_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(en_q) |-> ($past(ctrl_wr && wr_data[0]) && HAS_XLAT));
endmodule

// File: tb/tb_lpi_base_regs.sv
module tb_lpi_base_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        pend;
    logic        wide;
    logic        hi;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  // sequential: each expectation depends on the entries before it
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0100_FFFF_FFFF_FF9F},
    '{1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0800, 64'h0100_FFFF_0000_0780},
    '{1'b0, 1'b0, 1'b1, 64'h0000_0000_030F_1234, 64'h0100_1234_0000_0780},
    '{1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0380},
    '{1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4100_FFFF_FFFF_0F80},
    '{1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0500, 64'h4100_FFFF_0000_0500},
    '{1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0500},
    '{1'b0, 1'b1, 1'b0, 64'h0200_0000_0000_0100, 64'h0100_0000_0000_0100}
  };

  logic        clk, rst_n, wr_en, wr_wide, rd_wide;
  logic [4:0]  wr_addr, rd_addr;
  logic [63:0] wr_data, rd_data, rd_data2;
  logic [63:0] prop_base, pend_base, prop_base2, pend_base2;
  logic        lpi_en, lpi_start, lpi_en2, lpi_start2;
  int          n_run, n_fail;

  lpi_base_regs #(.HAS_XLAT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_data(rd_data),
    .prop_base(prop_base), .pend_base(pend_base), .lpi_en(lpi_en), .lpi_start(lpi_start));

  lpi_base_regs #(.HAS_XLAT(1'b0)) dut_noxlat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_data(rd_data2),
    .prop_base(prop_base2), .pend_base(pend_base2), .lpi_en(lpi_en2), .lpi_start(lpi_start2));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_wide = wide; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic wide, output logic [63:0] v);
    rd_addr = a; rd_wide = wide;
    #1;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] v;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_wide = 1'b0; wr_data = '0;
    rd_addr = '0; rd_wide = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 prop_base", prop_base, 64'h0);
    check("R12 pend_base", pend_base, 64'h0);
    check("R12 lpi_en", {63'h0, lpi_en}, 64'h0);
    check("R12 lpi_start", {63'h0, lpi_start}, 64'h0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 on stored value, R11 on reads
    for (int i = 0; i < 8; i++) begin
      logic [4:0] base;
      base = VEC[i].pend ? 5'h10 : 5'h08;
      wr(base | (VEC[i].hi ? 5'h04 : 5'h00), VEC[i].wide, VEC[i].data);
      check("R1/R2/R3/R4/R5/R6/R7 stored", VEC[i].pend ? pend_base : prop_base, VEC[i].exp);
      rd(base, 1'b1, v);
      check("R11 wide read", v, VEC[i].exp);
      rd(base, 1'b0, v);
      check("R11 low word read", v, {32'h0, VEC[i].exp[31:0]});
      rd(base | 5'h04, 1'b0, v);
      check("R11 high word read", v, {32'h0, VEC[i].exp[63:32]});
    end

    // R11 wide read with bit 2 set shifts the high word down
    rd(5'h0C, 1'b1, v);
    check("R11 wide read at +4", v, 64'h0000_0000_0100_0000);

    // R13 misaligned access
    wr(5'h09, 1'b0, 64'hFFFF_FFFF);
    check("R13 misaligned write ignored", prop_base, 64'h0100_0000_0000_0100);
    rd(5'h09, 1'b0, v);
    check("R13 misaligned read zero", v, 64'h0);

    // R9 / R10 enable and start pulse
    wr(5'h00, 1'b0, 64'h1);
    check("R9 enable set", {63'h0, lpi_en}, 64'h1);
    check("R10 start pulse high", {63'h0, lpi_start}, 64'h1);
    check("R9 no translation: enable stays 0", {63'h0, lpi_en2}, 64'h0);
    check("R9 no translation: no start", {63'h0, lpi_start2}, 64'h0);
    rd(5'h00, 1'b0, v);
    check("R9 control read", v, 64'h1);
    check("R9 no translation control read", rd_data2, 64'h0);
    @(negedge clk);
    check("R10 start pulse one cycle", {63'h0, lpi_start}, 64'h0);

    // R8 lock
    wr(5'h08, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 prop locked", prop_base, 64'h0100_0000_0000_0100);
    wr(5'h10, 1'b0, 64'h0000_0000_0000_0F80);
    check("R8 pend locked", pend_base, 64'h0000_0000_0000_0500);

    // R10 redundant enable
    wr(5'h00, 1'b0, 64'h1);
    check("R10 no pulse on re-enable", {63'h0, lpi_start}, 64'h0);

    // disable, writes accepted again
    wr(5'h00, 1'b0, 64'h0);
    check("R9 enable cleared", {63'h0, lpi_en}, 64'h0);
    check("R10 no pulse on clear", {63'h0, lpi_start}, 64'h0);
    wr(5'h08, 1'b1, 64'h0);
    check("R8 unlocked write, R3 inner remap", prop_base, 64'h0000_0000_0000_0380);

    summary();
  end
endmodule